// File: doc/BRIEF.md
# Interrupt Pin Trigger and Acknowledge Engine

This block sits between a bank of interrupt input pins and the message port that carries interrupts to the processor side. Each pin has a routing entry (mask, polarity, trigger mode, vector, destination, destination mode and delivery mode) supplied from a table held elsewhere. The block keeps one request bit and one remote-pending bit per pin. It decides when a pin event turns into an outgoing message and reports events that were absorbed into an interrupt that was already outstanding.

A pin is sampled only in cycles where its strobe is high. Each strobe stands for one report of the pin's current level. Edge-mode pins raise a message on a low-to-high change of their effective level. Level-mode pins raise one message and then stay blocked until the processor side sends an end-of-interrupt for their vector. An end-of-interrupt is compared with the vector of every entry at once. In level mode it clears the remote-pending bit of each matching entry and can queue a fresh message at once when that pin is still asserted. Queued messages leave one per cycle through a valid/ready port, lowest pin first.

Top module: `irq_route_engine`

## Requirements
- R1: The effective level of a pin is its raw level XOR the entry polarity bit. A strobe with effective level 1 sets the pin's request bit (`irr_state`); a strobe with effective level 0 clears it. Pins without a strobe keep their request bit.
- R2: For an edge-mode entry (`ent_lvl_trig`=0), an effective-high strobe queues a message only if the request bit was 0 before that strobe. Otherwise `coalesced` pulses for that pin in the following cycle.
- R3: For a level-mode entry (`ent_lvl_trig`=1), an effective-high strobe queues a message only while the remote-pending bit (`rirr_state`) is clear. Otherwise `coalesced` pulses. A strobe that finds a message from the same pin still queued also pulses `coalesced`.
- R4: A masked entry never queues a message and never pulses `coalesced`, though its request bit still follows R1.
- R5: Queuing a message for a level-mode entry sets that entry's remote-pending bit in the same clock edge.
- R6: An end-of-interrupt pulses `eoi_ack` for one cycle on every pin whose vector equals `eoi_vector`. When `eoi_level`=1, each matching pin's remote-pending bit is cleared. If that pin is unmasked and its request bit is set, a new message is queued (and, in level mode, remote-pending is set again).
- R7: An end-of-interrupt with `eoi_level`=0 pulses `eoi_ack` on matching pins and leaves every remote-pending bit unchanged.
- R8: A message from pin 0 carries destination mode 0 (physical) and `boot_cpu_id` as destination, whatever the entry holds.
- R9: A message carries the entry vector, trigger mode and destination. `msg_dmode` holds the 3-bit delivery mode shifted left by 8 (bits 10:8), `msg_level` is 1 and `msg_shorthand` is 0.
- R10: `msg_valid` is high while any message is queued. `msg_pin` names the lowest queued pin, and a message leaves the queue only in a cycle with `msg_valid` and `msg_ready` both high.
- R11: After reset all request, remote-pending and queued bits are 0, and `msg_valid`, `coalesced` and `eoi_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_strobe | input | NPINS | Per-pin sample strobe |
| pin_level | input | NPINS | Raw pin level, used when strobed |
| ent_mask | input | NPINS | Entry mask |
| ent_pol | input | NPINS | Entry polarity (1 = active low) |
| ent_lvl_trig | input | NPINS | Trigger mode (1 = level) |
| ent_logical | input | NPINS | Entry destination mode (1 = logical) |
| ent_vector | input | NPINS*8 | Entry vectors, pin i at bits 8i+7:8i |
| ent_dest | input | NPINS*8 | Entry destinations, pin i at bits 8i+7:8i |
| ent_dmode | input | NPINS*3 | Entry delivery modes, pin i at bits 3i+2:3i |
| boot_cpu_id | input | 8 | Boot processor ID used for pin 0 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-mode acknowledge |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | Receiver takes the offered message |
| msg_pin | output | 3 | Pin the message comes from |
| msg_dest | output | 8 | Destination ID |
| msg_vector | output | 8 | Vector |
| msg_logical | output | 1 | Destination mode |
| msg_lvl_trig | output | 1 | Trigger mode |
| msg_dmode | output | 11 | Delivery mode shifted left by 8 |
| msg_level | output | 1 | Always 1 |
| msg_shorthand | output | 2 | Always 0 |
| coalesced | output | NPINS | One-cycle pulse per absorbed event |
| eoi_ack | output | NPINS | One-cycle acknowledge per matching pin |
| irr_state | output | NPINS | Request bits |
| rirr_state | output | NPINS | Remote-pending bits |

## Verification
The bench targets a repeated edge report while the request bit is already high. A design that keyed on the level instead of the change would send duplicates and never raise `coalesced`. It holds a level pin high across a level end-of-interrupt, which must produce a fresh message at once; a design that only cleared remote-pending would lose that interrupt. Edge-mode acknowledges must leave remote-pending intact, and masked pins must stay silent even when their conditions are met. Pin 0 routing and lowest-first ordering are checked under a stalled receiver, where a wrong arbiter would offer a higher pin or drop a queued one.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W       = 8;
  localparam int ID_W        = 8;
  localparam int DMODE_W     = 3;
  localparam int DMODE_SHIFT = 8;
  localparam int MSG_DMODE_W = DMODE_W + DMODE_SHIFT;
  localparam int SHORT_W     = 2;

  // Effective level after polarity inversion.
  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  // Delivery mode as placed in the outgoing message.
  function automatic logic [MSG_DMODE_W-1:0] place_dmode(input logic [DMODE_W-1:0] m);
    return {m, {DMODE_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             raw,
  input  logic             pol,
  input  logic             mask,
  input  logic             lvl_trig,
  input  logic [VEC_W-1:0] vector,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             eoi_level,
  input  logic             take,
  output logic             pend_q,
  output logic             irr_q,
  output logic             rirr_q,
  output logic             coal_q,
  output logic             ack_q
);
  logic eff, evt_hi, evt_lo, vec_hit, eoi_clr;
  logic rirr_mid, irr_nx, pend_busy, pin_ok, pin_go, redo, queue;

  assign eff       = eff_level(raw, pol);
  assign evt_hi    = strobe & eff;
  assign evt_lo    = strobe & ~eff;
  assign vec_hit   = eoi_valid & (vector == eoi_vector);
  assign eoi_clr   = vec_hit & eoi_level;
  assign rirr_mid  = rirr_q & ~eoi_clr;
  assign irr_nx    = evt_hi ? 1'b1 : (evt_lo ? 1'b0 : irr_q);
  assign pend_busy = pend_q & ~take;
  assign pin_ok    = lvl_trig ? ~rirr_mid : ~irr_q;
  assign pin_go    = evt_hi & ~mask & pin_ok & ~pend_busy;
  assign redo      = eoi_clr & ~mask & irr_nx & ~pend_busy;
  assign queue     = pin_go | redo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irr_q  <= 1'b0;
      rirr_q <= 1'b0;
      coal_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      pend_q <= pend_busy | queue;
      irr_q  <= irr_nx;
      rirr_q <= rirr_mid | (queue & lvl_trig);
      coal_q <= evt_hi & ~mask & (~pin_ok | pend_busy);
      ack_q  <= vec_hit;
    end
  end

  // R4: a newly queued message never comes from a masked entry
  a_r4_masked_never_queues: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(!mask));

  // R5: a level-mode queue sets remote-pending alongside
  a_r5_level_sets_remote: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_q) && $past(lvl_trig)) |-> rirr_q);

  // R4: masked entries never report coalescing
  a_r4_masked_no_coalesce: assert property (@(posedge clk) disable iff (!rst_n)
    coal_q |-> $past(!mask));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NPINS = 8,
  localparam int PW = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] grant,
  output logic [PW-1:0]    idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = PW'(i);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_msg_fmt.sv
module irq_msg_fmt
  import irq_route_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int PW = $clog2(NPINS)
) (
  input  logic [PW-1:0]            idx,
  input  logic [NPINS-1:0]         ent_logical,
  input  logic [NPINS-1:0]         ent_lvl_trig,
  input  logic [NPINS*VEC_W-1:0]   ent_vector,
  input  logic [NPINS*ID_W-1:0]    ent_dest,
  input  logic [NPINS*DMODE_W-1:0] ent_dmode,
  input  logic [ID_W-1:0]          boot_cpu_id,
  output logic [ID_W-1:0]          dest,
  output logic [VEC_W-1:0]         vector,
  output logic                     logical,
  output logic                     lvl_trig,
  output logic [MSG_DMODE_W-1:0]   dmode,
  output logic                     level,
  output logic [SHORT_W-1:0]       shorthand
);
  logic boot_pin;
  assign boot_pin  = (idx == '0);
  assign vector    = ent_vector[idx*VEC_W +: VEC_W];
  assign lvl_trig  = ent_lvl_trig[idx];
  assign dmode     = place_dmode(ent_dmode[idx*DMODE_W +: DMODE_W]);
  assign dest      = boot_pin ? boot_cpu_id : ent_dest[idx*ID_W +: ID_W];
  assign logical   = boot_pin ? 1'b0 : ent_logical[idx];
  assign level     = 1'b1;
  assign shorthand = '0;
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NPINS = 8,
  localparam int PW = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pin_strobe,
  input  logic [NPINS-1:0]         pin_level,
  input  logic [NPINS-1:0]         ent_mask,
  input  logic [NPINS-1:0]         ent_pol,
  input  logic [NPINS-1:0]         ent_lvl_trig,
  input  logic [NPINS-1:0]         ent_logical,
  input  logic [NPINS*VEC_W-1:0]   ent_vector,
  input  logic [NPINS*ID_W-1:0]    ent_dest,
  input  logic [NPINS*DMODE_W-1:0] ent_dmode,
  input  logic [ID_W-1:0]          boot_cpu_id,
  input  logic                     eoi_valid,
  input  logic [VEC_W-1:0]         eoi_vector,
  input  logic                     eoi_level,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [PW-1:0]            msg_pin,
  output logic [ID_W-1:0]          msg_dest,
  output logic [VEC_W-1:0]         msg_vector,
  output logic                     msg_logical,
  output logic                     msg_lvl_trig,
  output logic [MSG_DMODE_W-1:0]   msg_dmode,
  output logic                     msg_level,
  output logic [SHORT_W-1:0]       msg_shorthand,
  output logic [NPINS-1:0]         coalesced,
  output logic [NPINS-1:0]         eoi_ack,
  output logic [NPINS-1:0]         irr_state,
  output logic [NPINS-1:0]         rirr_state
);
  logic [NPINS-1:0] pend, grant, take;
  logic             fire;

  assign fire = msg_valid & msg_ready;
  assign take = grant & {NPINS{fire}};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irq_pin_slice u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (pin_strobe[g]),
      .raw        (pin_level[g]),
      .pol        (ent_pol[g]),
      .mask       (ent_mask[g]),
      .lvl_trig   (ent_lvl_trig[g]),
      .vector     (ent_vector[g*VEC_W +: VEC_W]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .eoi_level  (eoi_level),
      .take       (take[g]),
      .pend_q     (pend[g]),
      .irr_q      (irr_state[g]),
      .rirr_q     (rirr_state[g]),
      .coal_q     (coalesced[g]),
      .ack_q      (eoi_ack[g])
    );
  end

  irq_pick #(.NPINS(NPINS)) u_pick (
    .req   (pend),
    .grant (grant),
    .idx   (msg_pin),
    .any   (msg_valid)
  );

  irq_msg_fmt #(.NPINS(NPINS)) u_fmt (
    .idx          (msg_pin),
    .ent_logical  (ent_logical),
    .ent_lvl_trig (ent_lvl_trig),
    .ent_vector   (ent_vector),
    .ent_dest     (ent_dest),
    .ent_dmode    (ent_dmode),
    .boot_cpu_id  (boot_cpu_id),
    .dest         (msg_dest),
    .vector       (msg_vector),
    .logical      (msg_logical),
    .lvl_trig     (msg_lvl_trig),
    .dmode        (msg_dmode),
    .level        (msg_level),
    .shorthand    (msg_shorthand)
  );

  // R10: the arbiter grants at most one pin
  a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10: an offered message that is not taken stays offered
  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid);

  // R8: pin 0 goes physical to the boot processor
  a_r8_pin0_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_pin == '0) |-> (!msg_logical && msg_dest == boot_cpu_id));

  // R7: an edge-mode acknowledge never clears remote-pending
  a_r7_edge_eoi_keeps_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !eoi_level) |=> ((rirr_state & $past(rirr_state)) == $past(rirr_state)));
endmodule

// File: tb/sim_irq_route_engine.sv
module sim_irq_route_engine;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   pin_strobe = '0, pin_level = '0, ent_mask = '0, ent_pol = '0;
  logic [N-1:0]   ent_lvl_trig = '0, ent_logical = '0;
  logic [N*8-1:0] ent_vector = '0, ent_dest = '0;
  logic [N*3-1:0] ent_dmode = '0;
  logic [7:0]     boot_cpu_id = '0, eoi_vector = '0;
  logic           eoi_valid = 1'b0, eoi_level = 1'b0, msg_ready = 1'b0;
  logic           msg_valid, msg_logical, msg_lvl_trig, msg_level;
  logic [2:0]     msg_pin;
  logic [7:0]     msg_dest, msg_vector;
  logic [10:0]    msg_dmode;
  logic [1:0]     msg_shorthand;
  logic [N-1:0]   coalesced, eoi_ack, irr_state, rirr_state;

  int tests = 0, fails = 0;
  logic [N-1:0] m_irr = '0, m_rirr = '0, m_pend = '0, m_coal = '0, m_ack = '0;

  always #2 clk = ~clk;

  irq_route_engine #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_strobe(pin_strobe), .pin_level(pin_level),
    .ent_mask(ent_mask), .ent_pol(ent_pol), .ent_lvl_trig(ent_lvl_trig),
    .ent_logical(ent_logical), .ent_vector(ent_vector), .ent_dest(ent_dest),
    .ent_dmode(ent_dmode), .boot_cpu_id(boot_cpu_id), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .eoi_level(eoi_level), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_pin(msg_pin), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_logical(msg_logical), .msg_lvl_trig(msg_lvl_trig),
    .msg_dmode(msg_dmode), .msg_level(msg_level), .msg_shorthand(msg_shorthand),
    .coalesced(coalesced), .eoi_ack(eoi_ack), .irr_state(irr_state),
    .rirr_state(rirr_state)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Next-state model written from the requirements.
  task automatic model_step();
    logic [N-1:0] n_irr, n_rirr, n_pend, n_coal, n_ack;
    int tk;
    tk = (msg_ready && m_pend != 0) ? lowest(m_pend) : -1;
    for (int i = 0; i < N; i++) begin
      logic eff, hit, r, busy, ok, go, again;
      eff   = pin_level[i] ^ ent_pol[i];
      hit   = eoi_valid && (ent_vector[i*8 +: 8] == eoi_vector);
      r     = m_rirr[i] && !(hit && eoi_level);
      busy  = m_pend[i] && (tk != i);
      n_irr[i] = pin_strobe[i] ? eff : m_irr[i];
      if (ent_lvl_trig[i]) ok = !r;
      else ok = !m_irr[i];
      go    = pin_strobe[i] && eff && !ent_mask[i] && ok && !busy;
      again = hit && eoi_level && !ent_mask[i] && n_irr[i] && !busy;
      n_coal[i] = pin_strobe[i] && eff && !ent_mask[i] && (!ok || busy);
      n_pend[i] = busy || go || again;
      n_rirr[i] = r || ((go || again) && ent_lvl_trig[i]);
      n_ack[i]  = hit;
    end
    m_irr = n_irr; m_rirr = n_rirr; m_pend = n_pend; m_coal = n_coal; m_ack = n_ack;
  endtask

  task automatic compare_all();
    int p;
    check("R1 irr_state", 32'(irr_state), 32'(m_irr));
    check("R5/R6 rirr_state", 32'(rirr_state), 32'(m_rirr));
    check("R2/R3 coalesced", 32'(coalesced), 32'(m_coal));
    check("R6/R7 eoi_ack", 32'(eoi_ack), 32'(m_ack));
    check("R10 msg_valid", 32'(msg_valid), 32'(m_pend != 0));
    if (m_pend != 0) begin
      p = lowest(m_pend);
      check("R10 msg_pin", 32'(msg_pin), 32'(p));
      check("R9 msg_vector", 32'(msg_vector), 32'(ent_vector[p*8 +: 8]));
      check("R9 msg_lvl_trig", 32'(msg_lvl_trig), 32'(ent_lvl_trig[p]));
      check("R9 msg_dmode", 32'(msg_dmode), 32'(ent_dmode[p*3 +: 3]) * 256);
      check("R9 level/shorthand", {29'd0, msg_level, msg_shorthand}, 32'h4);
      if (p == 0) begin
        check("R8 pin0 dest", 32'(msg_dest), 32'(boot_cpu_id));
        check("R8 pin0 mode", 32'(msg_logical), 32'h0);
      end else begin
        check("R9 msg_dest", 32'(msg_dest), 32'(ent_dest[p*8 +: 8]));
        check("R9 msg_logical", 32'(msg_logical), 32'(ent_logical[p]));
      end
    end
  endtask

  // Called at a falling edge with inputs set; returns at the next falling edge.
  task automatic run_cycle();
    model_step();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
    pin_strobe = '0;
    eoi_valid  = 1'b0;
  endtask

  task automatic strobe_pin(input int p, input logic lv);
    pin_strobe[p] = 1'b1;
    pin_level[p]  = lv;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset msg_valid", 32'(msg_valid), 32'h0);
    check("R11 reset state", {8'd0, irr_state, rirr_state, coalesced | eoi_ack}, 32'h0);
    rst_n = 1'b1;

    // directed configuration
    boot_cpu_id = 8'h0A;
    ent_vector[0*8 +: 8] = 8'h20; ent_dest[0*8 +: 8] = 8'h05; ent_logical[0] = 1'b1;
    ent_vector[1*8 +: 8] = 8'h31; ent_dest[1*8 +: 8] = 8'h11; ent_dmode[1*3 +: 3] = 3'd1;
    ent_vector[2*8 +: 8] = 8'h42; ent_dest[2*8 +: 8] = 8'h22; ent_lvl_trig[2] = 1'b1;
    ent_dmode[2*3 +: 3] = 3'd7;
    ent_vector[3*8 +: 8] = 8'h53; ent_lvl_trig[3] = 1'b1; ent_mask[3] = 1'b1;
    ent_vector[4*8 +: 8] = 8'h64; ent_pol[4] = 1'b1;
    run_cycle();

    // R2: repeated edge report coalesces
    strobe_pin(1, 1'b1); run_cycle();
    check("R2 first edge queued", 32'(msg_pin), 32'd1);
    strobe_pin(1, 1'b1); run_cycle();
    check("R2 repeat edge coalesced", 32'(coalesced[1]), 32'h1);

    // R3 / R5: level pin holds off
    strobe_pin(2, 1'b1); run_cycle();
    check("R5 remote set", 32'(rirr_state[2]), 32'h1);
    strobe_pin(2, 1'b1); run_cycle();
    check("R3 level held off", 32'(coalesced[2]), 32'h1);

    // R4: masked level pin
    strobe_pin(3, 1'b1); run_cycle();
    check("R4 masked no coalesce", 32'(coalesced[3]), 32'h0);
    check("R4 masked irr follows", 32'(irr_state[3]), 32'h1);
    check("R4 masked no remote", 32'(rirr_state[3]), 32'h0);

    // R1: inverted polarity
    strobe_pin(4, 1'b0); run_cycle();
    check("R1 active-low pin", 32'(irr_state[4]), 32'h1);

    // R10: drain lowest first (pins 1,2,4 queued)
    check("R10 lowest offered", 32'(msg_pin), 32'd1);
    msg_ready = 1'b1; run_cycle();
    check("R10 next offered", 32'(msg_pin), 32'd2);
    run_cycle(); run_cycle();
    check("R10 drained", 32'(msg_valid), 32'h0);
    msg_ready = 1'b0;

    // R6: level EOI redelivers still-asserted pin 2
    eoi_valid = 1'b1; eoi_vector = 8'h42; eoi_level = 1'b1; run_cycle();
    check("R6 ack pin2", 32'(eoi_ack), 32'h4);
    check("R6 redelivered", 32'(msg_pin), 32'd2);
    check("R6 remote re-set", 32'(rirr_state[2]), 32'h1);

    // R7: edge EOI keeps remote
    eoi_valid = 1'b1; eoi_vector = 8'h42; eoi_level = 1'b0; run_cycle();
    check("R7 ack only", 32'(eoi_ack[2]), 32'h1);
    check("R7 remote kept", 32'(rirr_state[2]), 32'h1);

    // R8: pin 0 routing
    strobe_pin(0, 1'b1); run_cycle();
    check("R8 pin0 offered", 32'(msg_pin), 32'd0);
    check("R8 pin0 dest", 32'(msg_dest), 32'h0A);
    check("R8 pin0 physical", 32'(msg_logical), 32'h0);

    // random phase
    void'($urandom(32'd1234));
    for (int phase = 0; phase < 8; phase++) begin
      for (int i = 0; i < N; i++) begin
        ent_mask[i]     = ($urandom % 5) == 0;
        ent_pol[i]      = $urandom % 2;
        ent_lvl_trig[i] = $urandom % 2;
        ent_logical[i]  = $urandom % 2;
        ent_vector[i*8 +: 8] = 8'h40 + 8'($urandom % 4);
        ent_dest[i*8 +: 8]   = 8'($urandom);
        ent_dmode[i*3 +: 3]  = 3'($urandom);
      end
      boot_cpu_id = 8'($urandom);
      for (int c = 0; c < 400; c++) begin
        for (int i = 0; i < N; i++) begin
          pin_strobe[i] = ($urandom % 4) == 0;
          pin_level[i]  = $urandom % 2;
        end
        eoi_valid  = ($urandom % 6) == 0;
        eoi_vector = 8'h40 + 8'($urandom % 4);
        eoi_level  = $urandom % 2;
        msg_ready  = ($urandom % 3) != 0;
        run_cycle();
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule